// File: doc/BRIEF.md
# Set-Associative Tag Store with Line Permissions

This block is the tag half of a set-associative cache. For every way of every set it holds the tag of a cached line and a two-bit access permission. A cache controller drives one request per clock cycle over a single request port. Each request names an operation and a line-aligned address, and the answer comes back on the response port one cycle later. The block splits the address into a set index and a tag, compares the tag against every way of the selected set, and then, depending on the operation, grants or refuses an access, reports presence or free room, installs or removes a line, changes a line's permission, or names the line to evict.

Replacement is true least-recently-used and is kept per set as an age rank for each way. Any tag match on an access, and every successful allocation, makes the way concerned the youngest. The data array, the coherence protocol, miss handling and the memory interface all sit outside the block.

Top module: `tagperm_array`

## Requirements
- R1: After reset every way of every set holds permission absent (code 0), no response is pending (rsp_valid = 0), accesses to any set miss, and the availability check succeeds.
- R2: The set index is the address field just above the OFFSET_W block-offset bits, log2(SETS) bits wide. The stored tag is every bit above that field. A way matches (rsp_found = 1) only when its stored tag equals the request tag and its permission is not absent.
- R3: An access (op 0) is granted (rsp_hit = 1) when the matched line is read-write (code 3), or when it is read-only (code 2) and the kind is load (0) or fetch (1). A store (kind 2) to a read-only line, and any access to an invalid line (code 1), is refused while rsp_found is still 1.
- R4: An access that matches a line, granted or refused, makes that way the most recently used in its set. An access that misses leaves the replacement order unchanged.
- R5: The availability check (op 2) gives rsp_hit = 1 when the set already holds the tag or has at least one absent way.
- R6: Allocation (op 3) writes the tag into the lowest-numbered absent way, sets that way's permission to invalid, makes it most recently used, and returns its index on rsp_way with rsp_hit = 1.
- R7: Allocating a tag that is already present, or allocating into a set with no absent way, gives rsp_err = 1 and rsp_hit = 0, and changes neither the tags, the permissions nor the replacement order.
- R8: Deallocation (op 4) returns the matched way to absent, with rsp_hit = 1 and the way index. Deallocating a tag that is not present gives rsp_err = 1 and changes nothing.
- R9: A permission change (op 5) writes req_perm into the matched way, with rsp_hit = 1. When the tag is not present it gives rsp_err = 1 and changes nothing.
- R10: A victim probe (op 6) on a set with no absent way gives rsp_hit = 1, the least-recently-used way on rsp_way, and that way's line address (tag, set index, zero offset) on rsp_addr. On a set with an absent way it gives rsp_hit = 0. In both cases it leaves the replacement order unchanged.
- R11: Each accepted request (req_valid = 1) produces exactly one response with rsp_valid = 1 on the next cycle. Presence (op 1) reports rsp_hit = rsp_found. The reserved op 7 gives rsp_err = 1 and rsp_hit = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 access, 1 presence, 2 availability, 3 allocate, 4 deallocate, 5 permission change, 6 victim probe) |
| req_kind | input | 2 | Access kind: 0 load, 1 fetch, 2 store |
| req_perm | input | 2 | New permission for op 5: 0 absent, 1 invalid, 2 read-only, 3 read-write |
| req_addr | input | ADDR_W | Line-aligned request address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Grant or success flag of the operation |
| rsp_found | output | 1 | The request tag matched a non-absent way |
| rsp_err | output | 1 | Operation refused as illegal |
| rsp_way | output | log2(WAYS) | Matched, allocated or victim way |
| rsp_addr | output | ADDR_W | Victim line address for op 6, zero otherwise |

## Verification
Two functions meet at one clock edge: an allocation or a matching access writes the tag and permission arrays and updates the age ranks of the same set, and the request in the very next cycle reads both results. The bench provokes this with back-to-back requests to one set: an allocation followed at once by an access, a permission change followed by a store, and a burst of touches followed by a victim probe. A long stream of random operations on a small pool of tags in two sets then keeps each set near full, so the refusal paths and evictions are exercised often. Every response is compared with a reference model in the bench that applies the requirements in request order, so any update that comes a cycle late, or that is lost when two updates land at the same edge, shows up as a wrong way, grant or victim.

// File: rtl/tagperm_pkg.sv
// Shared encodings for the permission-checked tag store.
// Assumes every user compares against these names, not raw codes.
package tagperm_pkg;

    typedef enum logic [1:0] {
        PERM_ABSENT = 2'd0,
        PERM_INVAL  = 2'd1,
        PERM_RDONLY = 2'd2,
        PERM_RDWR   = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_STORE = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        OP_ACCESS  = 3'd0,
        OP_PRESENT = 3'd1,
        OP_AVAIL   = 3'd2,
        OP_ALLOC   = 3'd3,
        OP_DEALLOC = 3'd4,
        OP_SETPERM = 3'd5,
        OP_PROBE   = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

endpackage

// File: rtl/tagperm_addr_split.sv
// Splits a line-aligned address into set index and tag.
// Assumes: the offset bits are ignored and SETS is a power of two.
module tagperm_addr_split #(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 6,
    parameter int SETS     = 16,
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - OFFSET_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);

    // Set index sits just above the block offset; the tag is everything above.
    assign set_idx = addr[OFFSET_W +: IDX_W];
    assign tag     = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/tagperm_way_match.sv
// Compares one set's ways against a tag and finds the lowest free way.
// Assumes: at most one non-absent way holds a given tag.
module tagperm_way_match
    import tagperm_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row_tags,
    input  logic [WAYS-1:0][1:0]       row_perms,
    input  logic [TAG_W-1:0]           tag,
    output logic                       found,
    output logic [WAY_W-1:0]           match_way,
    output logic                       free_any,
    output logic [WAY_W-1:0]           free_way
);

    logic [WAYS-1:0] match_vec;
    logic [WAYS-1:0] free_vec;

    // Per-way compare: a match needs an equal tag and a present line.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign free_vec[w]  = (perm_e'(row_perms[w]) == PERM_ABSENT);
        assign match_vec[w] = !free_vec[w] && (row_tags[w] == tag);
    end

    // Priority encode both vectors, the lowest index winning.
    always_comb begin
        found     = 1'b0;
        match_way = '0;
        free_any  = 1'b0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                found     = 1'b1;
                match_way = WAY_W'(w);
            end
            if (free_vec[w]) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/tagperm_lru.sv
// True-LRU tracker: one age rank per way per set, 0 being youngest.
// Assumes: WAYS is a power of two; one touch per cycle at most.
module tagperm_lru #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim_way
);

    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
    logic [WAY_W-1:0]           touched_age;

    assign touched_age = age_q[touch_set][touch_way];

    // Reset ranks way 0 oldest; a touch makes one way youngest and ages the younger ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(WAYS - 1 - w);
                end
            end
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < touched_age) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    // The victim is the way holding the oldest rank.
    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[rd_set][w] == WAY_W'(WAYS - 1)) begin
                victim_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/tagperm_array.sv
// Set-associative tag store with per-line permissions and true-LRU replacement.
// Assumes: one request per cycle, line-aligned addresses; the response is registered.
module tagperm_array
    import tagperm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 6,
    parameter int SETS     = 16,
    parameter int WAYS     = 4,
    localparam int IDX_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int TAG_W   = ADDR_W - OFFSET_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_perm,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_found,
    output logic              rsp_err,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [ADDR_W-1:0] rsp_addr
);

    logic [WAYS-1:0][TAG_W-1:0] tag_mem  [SETS];
    logic [WAYS-1:0][1:0]       perm_mem [SETS];

    logic [IDX_W-1:0] set_idx;
    logic [TAG_W-1:0] req_tag;
    logic             found, free_any;
    logic [WAY_W-1:0] match_way, free_way, victim_way;
    perm_e            cur_perm;

    logic             wr_tag, wr_perm, touch, hit_n, err_n;
    logic [WAY_W-1:0] wr_way, way_n, touch_way;
    logic [1:0]       perm_n;
    logic [ADDR_W-1:0] addr_n;

    tagperm_addr_split #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS)) i_split (
        .addr(req_addr), .set_idx(set_idx), .tag(req_tag)
    );

    tagperm_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
        .row_tags(tag_mem[set_idx]), .row_perms(perm_mem[set_idx]), .tag(req_tag),
        .found(found), .match_way(match_way), .free_any(free_any), .free_way(free_way)
    );

    tagperm_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
        .clk(clk), .rst_n(rst_n), .touch(touch), .touch_set(set_idx),
        .touch_way(touch_way), .rd_set(set_idx), .victim_way(victim_way)
    );

    assign cur_perm = perm_e'(perm_mem[set_idx][match_way]);

    // Decode the operation into array writes, a replacement touch and the response.
    always_comb begin
        wr_tag    = 1'b0;
        wr_perm   = 1'b0;
        wr_way    = match_way;
        perm_n    = PERM_ABSENT;
        touch     = 1'b0;
        touch_way = match_way;
        hit_n     = 1'b0;
        err_n     = 1'b0;
        way_n     = match_way;
        addr_n    = '0;
        if (req_valid) begin
            case (op_e'(req_op))
                OP_ACCESS: begin
                    touch = found;
                    hit_n = found && ((cur_perm == PERM_RDWR) ||
                            ((cur_perm == PERM_RDONLY) &&
                             (kind_e'(req_kind) == KIND_LOAD || kind_e'(req_kind) == KIND_FETCH)));
                end
                OP_PRESENT: hit_n = found;
                OP_AVAIL:   hit_n = found || free_any;
                OP_ALLOC: begin
                    if (found || !free_any) begin
                        err_n = 1'b1;
                    end else begin
                        hit_n     = 1'b1;
                        wr_tag    = 1'b1;
                        wr_perm   = 1'b1;
                        wr_way    = free_way;
                        perm_n    = PERM_INVAL;
                        touch     = 1'b1;
                        touch_way = free_way;
                        way_n     = free_way;
                    end
                end
                OP_DEALLOC: begin
                    hit_n   = found;
                    err_n   = !found;
                    wr_perm = found;
                    perm_n  = PERM_ABSENT;
                end
                OP_SETPERM: begin
                    hit_n   = found;
                    err_n   = !found;
                    wr_perm = found;
                    perm_n  = req_perm;
                end
                OP_PROBE: begin
                    if (!free_any) begin
                        hit_n  = 1'b1;
                        way_n  = victim_way;
                        addr_n = {tag_mem[set_idx][victim_way], set_idx, OFFSET_W'(0)};
                    end
                end
                default: err_n = 1'b1;
            endcase
        end
    end

    // Array storage: reset clears every line to absent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tag_mem[s]  <= '0;
                perm_mem[s] <= '0;
            end
        end else begin
            if (wr_tag)  tag_mem[set_idx][wr_way]  <= req_tag;
            if (wr_perm) perm_mem[set_idx][wr_way] <= perm_n;
        end
    end

    // Response register: one cycle from request to answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_found <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_way   <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= hit_n;
            rsp_found <= req_valid && found;
            rsp_err   <= err_n;
            rsp_way   <= way_n;
            rsp_addr  <= addr_n;
        end
    end

endmodule

// File: rtl/tagperm_array_chk.sv
// Port-level protocol checks for tagperm_array, attached by bind.
// Assumes the op encodings of tagperm_pkg.
module tagperm_array_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       rsp_found,
    input logic       rsp_err
);

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    grant_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0) |=> (!rsp_hit || rsp_found));

    // R7
    alloc_one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3) |=> (rsp_hit != rsp_err));

    // R8
    err_excludes_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && !rsp_hit));

endmodule

bind tagperm_array tagperm_array_chk i_tagperm_array_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_found(rsp_found), .rsp_err(rsp_err)
);

// File: tb/test_tagperm_array.sv
// Scoreboard bench: a driver applies requests and queues model predictions,
// a monitor compares each response against the queue head.
module test_tagperm_array;

    localparam int ADDR_W = 32, OFFSET_W = 6, SETS = 16, WAYS = 4;
    localparam int IDX_W = $clog2(SETS), WAY_W = $clog2(WAYS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [1:0]        req_kind = '0;
    logic [1:0]        req_perm = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid, rsp_hit, rsp_found, rsp_err;
    logic [WAY_W-1:0]  rsp_way;
    logic [ADDR_W-1:0] rsp_addr;

    tagperm_array #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .WAYS(WAYS)) i_tagperm_array (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_kind(req_kind), .req_perm(req_perm), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_found(rsp_found),
        .rsp_err(rsp_err), .rsp_way(rsp_way), .rsp_addr(rsp_addr)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic        hit, found, err;
        int          way;
        bit          chk_way;
        logic [31:0] addr;
        bit          chk_addr;
        string       rq;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0, n_bad = 0;

    // Reference model state
    int m_tag [SETS][WAYS];
    int m_perm[SETS][WAYS];
    int m_age [SETS][WAYS];

    function automatic logic [31:0] mk(int tg, int st);
        return {tg[21:0], st[3:0], 6'b0};
    endfunction

    function automatic void m_touch(int s, int t);
        int a_t = m_age[s][t];
        for (int w = 0; w < WAYS; w++) begin
            if (w == t) m_age[s][w] = 0;
            else if (m_age[s][w] < a_t) m_age[s][w]++;
        end
    endfunction

    task automatic do_op(int op, int kind, int perm, logic [31:0] a, string rq);
        exp_t e;
        int s = int'(a[9:6]);
        int tg = int'(a[31:10]);
        int fw = -1, mw = -1, vw = 0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (m_perm[s][w] != 0 && m_tag[s][w] == tg) mw = w;
            if (m_perm[s][w] == 0) fw = w;
            if (m_age[s][w] == WAYS - 1) vw = w;
        end
        e.rq = rq; e.hit = 0; e.err = 0; e.found = (mw >= 0);
        e.way = (mw >= 0) ? mw : 0; e.chk_way = (mw >= 0);
        e.addr = '0; e.chk_addr = 0;
        case (op)
            0: begin
                if (mw >= 0) begin
                    e.hit = (m_perm[s][mw] == 3) || (m_perm[s][mw] == 2 && kind != 2);
                    m_touch(s, mw);
                end
            end
            1: e.hit = (mw >= 0);
            2: e.hit = (mw >= 0) || (fw >= 0);
            3: begin
                if (mw >= 0 || fw < 0) e.err = 1;
                else begin
                    e.hit = 1; e.way = fw; e.chk_way = 1;
                    m_tag[s][fw] = tg; m_perm[s][fw] = 1; m_touch(s, fw);
                end
            end
            4: begin
                e.hit = (mw >= 0); e.err = (mw < 0);
                if (mw >= 0) m_perm[s][mw] = 0;
            end
            5: begin
                e.hit = (mw >= 0); e.err = (mw < 0);
                if (mw >= 0) m_perm[s][mw] = perm;
            end
            6: begin
                if (fw < 0) begin
                    e.hit = 1; e.way = vw; e.chk_way = 1;
                    e.addr = mk(m_tag[s][vw], s); e.chk_addr = 1;
                end
            end
            default: e.err = 1;
        endcase
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_kind = 2'(kind);
        req_perm = 2'(perm); req_addr = a;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each response with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected response: actual valid=1 expected none");
            end else begin
                e = exp_q.pop_front();
                if (rsp_hit !== e.hit || rsp_found !== e.found || rsp_err !== e.err ||
                    (e.chk_way && int'(rsp_way) != e.way) ||
                    (e.chk_addr && rsp_addr !== e.addr)) begin
                    n_bad++;
                    $display("FAIL %s: actual hit=%0b found=%0b err=%0b way=%0d addr=%h expected hit=%0b found=%0b err=%0b way=%0d addr=%h",
                             e.rq, rsp_hit, rsp_found, rsp_err, rsp_way, rsp_addr,
                             e.hit, e.found, e.err, e.way, e.addr);
                end
            end
        end
    end

    initial begin : watchdog
        #500000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = 0; m_perm[s][w] = 0; m_age[s][w] = WAYS - 1 - w;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state: nothing pending
        n_vec++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual rsp_valid=%0b expected 0", rsp_valid);
        end
        do_op(0, 0, 0, mk(0, 0),   "R1 access after reset misses");
        do_op(2, 0, 0, mk(5, 3),   "R1 avail after reset");
        do_op(6, 0, 0, mk(5, 3),   "R10 probe with free way");
        // R6 allocation fills lowest ways; back-to-back access sees it
        do_op(3, 0, 0, mk(10, 3),  "R6 alloc way0");
        do_op(0, 0, 0, mk(10, 3),  "R3 access to invalid line refused");
        do_op(3, 0, 0, mk(11, 3),  "R6 alloc way1");
        do_op(3, 0, 0, mk(12, 3),  "R6 alloc way2");
        do_op(3, 0, 0, mk(13, 3),  "R6 alloc way3");
        do_op(2, 0, 0, mk(14, 3),  "R5 avail full set new tag");
        do_op(2, 0, 0, mk(12, 3),  "R5 avail full set held tag");
        do_op(3, 0, 0, mk(14, 3),  "R7 alloc into full set");
        do_op(3, 0, 0, mk(11, 3),  "R7 alloc already present");
        do_op(6, 0, 0, mk(14, 3),  "R7 probe unchanged after refused alloc");
        do_op(1, 0, 0, mk(12, 7),  "R2 same tag other set not present");
        // R3 grant rules
        do_op(5, 0, 2, mk(11, 3),  "R9 set read-only");
        do_op(0, 0, 0, mk(11, 3),  "R3 load to read-only");
        do_op(0, 1, 0, mk(11, 3),  "R3 fetch to read-only");
        do_op(0, 2, 0, mk(11, 3),  "R3 store to read-only refused");
        do_op(5, 0, 3, mk(11, 3),  "R9 set read-write");
        do_op(0, 2, 0, mk(11, 3),  "R3 store to read-write");
        do_op(5, 0, 3, mk(20, 3),  "R9 permission change miss");
        // R4 refused access still touches
        do_op(0, 2, 0, mk(10, 3),  "R4 refused store to invalid touches");
        do_op(6, 0, 0, mk(0, 3),   "R10 victim after touches");
        do_op(0, 0, 0, mk(99, 3),  "R4 miss leaves order");
        do_op(6, 0, 0, mk(0, 3),   "R10 victim after miss");
        // R8 deallocation
        do_op(4, 0, 0, mk(12, 3),  "R8 dealloc");
        do_op(1, 0, 0, mk(12, 3),  "R8 gone after dealloc");
        do_op(4, 0, 0, mk(12, 3),  "R8 dealloc not present");
        do_op(3, 0, 0, mk(15, 3),  "R6 alloc reuses freed way");
        do_op(7, 0, 0, mk(15, 3),  "R11 reserved op");
        // Mixed traffic on two sets with a small tag pool
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 6);
            int tg = $urandom_range(30, 36);
            int st = ($urandom_range(0, 1) == 0) ? 5 : 9;
            do_op(op, $urandom_range(0, 2), $urandom_range(0, 3), mk(tg, st), "R4 mixed traffic");
            if ($urandom_range(0, 9) == 0) idle();
        end
        idle();
        repeat (4) @(negedge clk);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R11 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule